// File: doc/BRIEF.md
# Majority-Clocked Three-Register Keystream Generator

This block produces a bit-serial keystream from three binary linear feedback shift registers of 19, 22 and 23 stages, which together hold a 64-bit state. A start pulse captures a 64-bit secret key and a 22-bit frame number. The block then runs through its phases in order. It clears its state, then shifts in the key and then the frame number with every register stepping on every clock. Next it runs a fixed number of mixing steps with no output, where only some registers move on each step. Finally it emits one frame of keystream bits.

During mixing and output, one control stage of each register takes part in a majority vote. Only the registers whose control stage agrees with the majority move, so either two or three registers step each time. The keystream leaves on a valid/ready stream of one bit per beat. The host re-keys for the next frame by pulsing start again with the same key and the next frame number.

Top module: `mkg_core`

## Requirements
- R1: After reset, and after any reset applied during a frame, `busy`, `ks_valid` and `frame_done` are 0.
- R2: A `start` pulse while `busy` is 0 begins a frame, and `busy` is 1 from the next cycle. A `start` pulse while `busy` is 1 is ignored: the frame in progress and its keystream are unchanged.
- R3: Loading begins by clearing all stages to zero. It then takes 64 regular clocks carrying key bits `key[0]` first, followed by 22 regular clocks carrying frame bits `iv[0]` first. On each of these clocks every register shifts toward its highest stage. Its new stage 0 is the XOR of its feedback taps and the current input bit. The taps are stages 18,17,16,13 for the 19-stage register, stages 21,20 for the 22-stage register, and stages 22,21,20,7 for the 23-stage register.
- R4: On each majority step, the control bits are stage 8, stage 10 and stage 10 of the 19-, 22- and 23-stage registers. Only the registers whose control bit equals the majority of the three bits shift, so two or three registers move on every step.
- R5: 100 majority steps follow loading, and no output is produced during them. With the `start` pulse sampled at clock edge 0, `ks_valid` first goes to 1 right after edge 187.
- R6: Each keystream bit is the XOR of the highest stage of all three registers, taken right after one further majority step. Bit n of the frame follows mixing step 100+n.
- R7: A frame carries exactly 228 bits. `frame_done` is 1 for exactly one cycle, in the cycle after the last bit is accepted. In that cycle `busy` and `ks_valid` are 0.
- R8: Back-pressure: while `ks_valid` is 1 and `ks_ready` is 0, `ks_bit` and all register contents hold. A bit transfers on a clock edge where both are 1, and the next bit appears after that edge. The bit sequence does not depend on the `ks_ready` pattern.
- R9: Each frame depends only on the key and frame number captured at its own start. A frame started after an earlier frame, or after a reset, gives the same bits as a fresh run would.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins a frame when idle |
| key | input | 64 | Secret key, captured at start |
| iv | input | 22 | Frame number, captured at start |
| busy | output | 1 | High from start until the frame ends |
| ks_bit | output | 1 | Keystream bit, meaningful while ks_valid is high |
| ks_valid | output | 1 | Keystream beat available |
| ks_ready | input | 1 | Consumer accepts the current beat |
| frame_done | output | 1 | One-cycle pulse after the last bit of a frame |

## Verification
A bench-side model of the registers generates the expected keystream for several kinds of load. An all-zero key and frame number must give all-zero output, which confirms that nothing leaks in through the feedback. Two consecutive frame numbers under one key show that the frame bits really reach the state. All-ones and sparse keys drive the majority vote into different agreement patterns, so an error in the taps, the control-stage choice or the bit order breaks the comparison. The frames run under three `ks_ready` patterns: always high, two-of-three, and irregular. Running the same loads under these patterns separates true back-pressure holds from lost or repeated bits. Directed runs add a start pulse in mid-frame and a reset in mid-frame.

// File: rtl/mkg_pkg.sv
package mkg_pkg;
  localparam int NREG   = 3;
  localparam int MAXLEN = 23;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_KEY  = 3'd1,
    PH_IV   = 3'd2,
    PH_MIX  = 3'd3,
    PH_OUT  = 3'd4
  } phase_t;

  function automatic int reg_len(input int i);
    case (i)
      0:       return 19;
      1:       return 22;
      default: return 23;
    endcase
  endfunction

  function automatic int reg_ctap(input int i);
    case (i)
      0:       return 8;
      default: return 10;
    endcase
  endfunction

  // feedback masks, one bit per tapped stage
  function automatic logic [MAXLEN-1:0] reg_taps(input int i);
    case (i)
      0:       return 23'h072000;
      1:       return 23'h300000;
      default: return 23'h700080;
    endcase
  endfunction

  function automatic int max4(input int a, input int b, input int c, input int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction
endpackage

// File: rtl/mkg_lfsr.sv
module mkg_lfsr #(
  parameter int               LEN  = 19,
  parameter int               MAXW = 23,
  parameter logic [MAXW-1:0]  TAPS = 23'h072000,
  parameter int               CTAP = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic shift,
  input  logic inj,
  output logic ctl,
  output logic msb
);
  logic [LEN-1:0] st;
  logic           fb;

  always_comb fb = (^(st & TAPS[LEN-1:0])) ^ inj;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     st <= '0;
    else if (clr)   st <= '0;
    else if (shift) st <= {st[LEN-2:0], fb};
  end

  assign ctl = st[CTAP];
  assign msb = st[LEN-1];
endmodule

// File: rtl/mkg_vote.sv
module mkg_vote #(
  parameter int N = 3
) (
  input  logic [N-1:0] ctl,
  output logic [N-1:0] en
);
  logic maj;
  always_comb begin
    maj = (ctl[0] & ctl[1]) | (ctl[0] & ctl[2]) | (ctl[1] & ctl[2]);
    en  = ~(ctl ^ {N{maj}});
  end
endmodule

// File: rtl/mkg_seq.sv
module mkg_seq
  import mkg_pkg::*;
#(
  parameter int KEY_W      = 64,
  parameter int IV_W       = 22,
  parameter int MIX_STEPS  = 100,
  parameter int FRAME_BITS = 228
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [KEY_W-1:0]  key,
  input  logic [IV_W-1:0]   iv,
  input  logic              ks_ready,
  input  logic [NREG-1:0]   maj_en,
  output logic              clr,
  output logic [NREG-1:0]   shift_en,
  output logic              inj,
  output logic              busy,
  output logic              ks_valid,
  output logic              frame_done,
  output phase_t            ph
);
  localparam int LD_W  = KEY_W + IV_W;
  localparam int CNT_W = $clog2(max4(KEY_W, IV_W, MIX_STEPS, FRAME_BITS) + 1);
  localparam logic [CNT_W-1:0] KEY_LAST = CNT_W'(KEY_W - 1);
  localparam logic [CNT_W-1:0] IV_LAST  = CNT_W'(IV_W - 1);
  localparam logic [CNT_W-1:0] MIX_LAST = CNT_W'(MIX_STEPS - 1);
  localparam logic [CNT_W-1:0] FR_BITS  = CNT_W'(FRAME_BITS);

  logic [LD_W-1:0]  ld;
  logic [CNT_W-1:0] cnt;
  logic             vld;
  logic             adv;
  logic             more;

  always_comb begin
    adv  = !vld || ks_ready;
    more = cnt < FR_BITS;
    clr  = (ph == PH_IDLE) && start;
    inj  = ((ph == PH_KEY) || (ph == PH_IV)) ? ld[0] : 1'b0;
    case (ph)
      PH_KEY, PH_IV: shift_en = '1;
      PH_MIX:        shift_en = maj_en;
      PH_OUT:        shift_en = (adv && more) ? maj_en : '0;
      default:       shift_en = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph         <= PH_IDLE;
      ld         <= '0;
      cnt        <= '0;
      vld        <= 1'b0;
      frame_done <= 1'b0;
    end else begin
      frame_done <= 1'b0;
      case (ph)
        PH_IDLE: begin
          if (start) begin
            ld  <= {iv, key};
            cnt <= '0;
            ph  <= PH_KEY;
          end
        end
        PH_KEY: begin
          ld <= ld >> 1;
          if (cnt == KEY_LAST) begin
            cnt <= '0;
            ph  <= PH_IV;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        PH_IV: begin
          ld <= ld >> 1;
          if (cnt == IV_LAST) begin
            cnt <= '0;
            ph  <= PH_MIX;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        PH_MIX: begin
          if (cnt == MIX_LAST) begin
            cnt <= '0;
            ph  <= PH_OUT;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        PH_OUT: begin
          if (adv) begin
            if (more) begin
              vld <= 1'b1;
              cnt <= cnt + 1'b1;
            end else begin
              vld        <= 1'b0;
              frame_done <= 1'b1;
              ph         <= PH_IDLE;
            end
          end
        end
        default: ph <= PH_IDLE;
      endcase
    end
  end

  assign busy     = (ph != PH_IDLE);
  assign ks_valid = vld;
endmodule

// File: rtl/mkg_core.sv
module mkg_core
  import mkg_pkg::*;
#(
  parameter int KEY_W      = 64,
  parameter int IV_W       = 22,
  parameter int MIX_STEPS  = 100,
  parameter int FRAME_BITS = 228
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [KEY_W-1:0] key,
  input  logic [IV_W-1:0]  iv,
  output logic             busy,
  output logic             ks_bit,
  output logic             ks_valid,
  input  logic             ks_ready,
  output logic             frame_done
);
  logic [NREG-1:0] ctl;
  logic [NREG-1:0] msb;
  logic [NREG-1:0] maj_en;
  logic [NREG-1:0] shift_en;
  logic            clr;
  logic            inj;
  phase_t          ph;

  mkg_seq #(
    .KEY_W(KEY_W), .IV_W(IV_W), .MIX_STEPS(MIX_STEPS), .FRAME_BITS(FRAME_BITS)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .key(key), .iv(iv),
    .ks_ready(ks_ready), .maj_en(maj_en), .clr(clr), .shift_en(shift_en),
    .inj(inj), .busy(busy), .ks_valid(ks_valid), .frame_done(frame_done),
    .ph(ph)
  );

  mkg_vote #(.N(NREG)) u_vote (.ctl(ctl), .en(maj_en));

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    mkg_lfsr #(
      .LEN(reg_len(g)), .MAXW(MAXLEN), .TAPS(reg_taps(g)), .CTAP(reg_ctap(g))
    ) u_lfsr (
      .clk(clk), .rst_n(rst_n), .clr(clr), .shift(shift_en[g]),
      .inj(inj), .ctl(ctl[g]), .msb(msb[g])
    );
  end

  assign ks_bit = ^msb;
endmodule

// File: rtl/mkg_core_chk.sv
module mkg_core_chk
  import mkg_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       busy,
  input logic       ks_bit,
  input logic       ks_valid,
  input logic       ks_ready,
  input logic       frame_done,
  input logic [2:0] shift_en,
  input phase_t     ph
);
  // R4
  two_or_three_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_MIX) |-> ($countones(shift_en) >= 2));

  // R5
  no_early_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ph != PH_OUT) |-> !ks_valid);

  // R8
  hold_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ks_valid && !ks_ready) |=> (ks_valid && $stable(ks_bit)));

  // R8
  stall_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ks_valid && !ks_ready) |-> (shift_en == 3'b000));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);

  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> (!busy && !ks_valid));

  // R2
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
endmodule

bind mkg_core mkg_core_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .ks_bit(ks_bit),
  .ks_valid(ks_valid), .ks_ready(ks_ready), .frame_done(frame_done),
  .shift_en(shift_en), .ph(ph)
);

// File: tb/test_mkg_core.sv
module test_mkg_core;
  localparam int NBITS = 228;
  localparam int NVEC  = 5;
  localparam logic [63:0] VKEY [NVEC] = '{
    64'h0, 64'h0123456789ABCDEF, 64'h0123456789ABCDEF,
    64'hFFFFFFFFFFFFFFFF, 64'h8000000000000001};
  localparam logic [21:0] VIV  [NVEC] = '{
    22'h0, 22'h000134, 22'h000135, 22'h3FFFFF, 22'h000001};
  localparam int VMODE [NVEC] = '{0, 0, 1, 2, 0};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [63:0] key = '0;
  logic [21:0] iv = '0;
  logic        ks_ready = 1'b1;
  logic        busy, ks_bit, ks_valid, frame_done;

  int checks = 0;
  int failures = 0;
  logic [NBITS-1:0] exp_bits;

  mkg_core i_mkg_core (
    .clk(clk), .rst_n(rst_n), .start(start), .key(key), .iv(iv),
    .busy(busy), .ks_bit(ks_bit), .ks_valid(ks_valid), .ks_ready(ks_ready),
    .frame_done(frame_done)
  );

  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // independent model built from R3, R4, R6
  task automatic model(input logic [63:0] k, input logic [21:0] f);
    logic [18:0] a;
    logic [21:0] b;
    logic [22:0] c;
    logic m, sa, sb, sc;
    a = '0; b = '0; c = '0;
    for (int i = 0; i < 86; i++) begin
      logic x;
      x = (i < 64) ? k[i] : f[i-64];
      a = {a[17:0], a[18]^a[17]^a[16]^a[13]^x};
      b = {b[20:0], b[21]^b[20]^x};
      c = {c[21:0], c[22]^c[21]^c[20]^c[7]^x};
    end
    for (int s = 0; s < 100 + NBITS; s++) begin
      m  = (a[8]&b[10]) | (a[8]&c[10]) | (b[10]&c[10]);
      sa = (a[8] == m); sb = (b[10] == m); sc = (c[10] == m);
      if (sa) a = {a[17:0], a[18]^a[17]^a[16]^a[13]};
      if (sb) b = {b[20:0], b[21]^b[20]};
      if (sc) c = {c[21:0], c[22]^c[21]^c[20]^c[7]};
      if (s >= 100) exp_bits[s-100] = a[18]^b[21]^c[22];
    end
  endtask

  task automatic run_frame(input logic [63:0] k, input logic [21:0] f,
                           input int mode, input int pulse_at);
    int cyc, n, first_v, last_cap, done_cyc, done_cnt;
    logic held, held_bit, rdy;
    model(k, f);
    @(negedge clk);
    key = k; iv = f; start = 1'b1; ks_ready = 1'b1;
    @(negedge clk);
    start = 1'b0;
    key = ~k; iv = ~f;   // captured values only matter (R9)
    chk("R2 busy after start", busy, 1);
    cyc = 0; n = 0; first_v = -1; last_cap = -1; done_cyc = -1; done_cnt = 0;
    held = 1'b0; held_bit = 1'b0;
    while (done_cnt == 0 && cyc < 6000) begin
      @(negedge clk);
      cyc++;
      case (mode)
        1:       rdy = (cyc % 3) != 0;
        2:       rdy = ((cyc ^ (cyc >> 2) ^ (cyc >> 5)) & 1) != 0;
        default: rdy = 1'b1;
      endcase
      ks_ready = rdy;
      start = (cyc == pulse_at);
      if (frame_done) begin
        done_cnt++;
        done_cyc = cyc;
        chk("R7 busy low at done", busy, 0);
        chk("R7 valid low at done", ks_valid, 0);
      end
      if (ks_valid) begin
        if (first_v < 0) first_v = cyc;
        if (held) chk("R8 bit held under stall", ks_bit, held_bit);
        if (!rdy) begin
          held = 1'b1; held_bit = ks_bit;
        end else begin
          held = 1'b0;
          if (n < NBITS) chk($sformatf("R6 bit %0d", n), ks_bit, exp_bits[n]);
          n++;
          last_cap = cyc;
        end
      end
    end
    start = 1'b0;
    chk("R5 first valid latency", first_v, 187);
    chk("R7 bit count", n, NBITS);
    chk("R7 done after last bit", done_cyc, last_cap + 1);
    @(negedge clk);
    chk("R7 done one cycle", frame_done, 0);
    ks_ready = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 busy in reset", busy, 0);
    chk("R1 valid in reset", ks_valid, 0);
    chk("R1 done in reset", frame_done, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle after reset", busy, 0);

    // vector table: R3 R4 R6 R8 R9 under several loads and ready patterns
    for (int v = 0; v < NVEC; v++) run_frame(VKEY[v], VIV[v], VMODE[v], -1);

    // R2 start during a frame is ignored
    run_frame(64'h0123456789ABCDEF, 22'h000134, 0, 100);
    run_frame(64'hA5A5_0F0F_3C3C_9696, 22'h2AAAAA, 2, 250);

    // R1 reset mid-frame, then R9 fresh frame
    @(negedge clk);
    key = 64'h1; iv = 22'h2; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (200) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 busy after mid reset", busy, 0);
    chk("R1 valid after mid reset", ks_valid, 0);
    rst_n = 1'b1;
    run_frame(64'h0123456789ABCDEF, 22'h000135, 1, -1);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule